// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block compares a programmed alarm time with the live calendar of a real-time clock, one field at a time. Six alarm registers hold seconds, minutes, hours, weekday, day of month and month. Each register is a BCD value in its low seven bits, plus a compare enable in bit 7. Software can therefore arm any subset of fields. For example, "every hour at minute 15" enables only the minute field. A register left at zero takes no part in the match.

The calendar counters sit outside the block and present their current BCD values on plain input pins. A one-cycle seconds strobe marks each counter update. On every strobe the block checks the enabled fields. When all of them agree, and at least one field is enabled, it sets a sticky alarm flag. The interrupt output is the flag gated by an interrupt enable bit. Software clears the flag by writing 0 to the flag bit of the control register.

The register bus is a plain single-cycle write port with a combinational read port. Every access completes in the cycle it is presented, so there is no back-pressure on either side. The time inputs and the strobe are plain status pins with no handshake.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, every alarm register reads 0x00, the control register reads 0x00, and both alarm_flag and alarm_irq are low.
- R2: A write to address 8, 9, 10, 11, 12 or 13 stores all 8 bits in the seconds, minutes, hours, weekday, day or month alarm register respectively, and a read of that address returns the stored byte. Address 14 is the control register: bit 3 is the interrupt enable (read/write) and bit 0 reads back the alarm flag; all other control bits read 0.
- R3: In an alarm register, bit 7 = 1 enables comparison of that field and bits 6:0 hold the BCD value, which is compared with the corresponding 8-bit time input (whose bit 7 is expected to be 0). A field with bit 7 = 0 is ignored, whatever its value bits and the time input hold.
- R4: The comparison only takes effect in a cycle where sec_tick is high; matching time inputs without a tick never set the flag.
- R5: When no alarm register has bit 7 set (for instance all written as 0x00), a tick never sets the flag.
- R6: A tick in which every enabled field equals its time input sets alarm_flag from the following cycle on. The flag stays set through later ticks that do not match.
- R7: A control write with bit 0 = 0 clears the flag from the next cycle on; a control write with bit 0 = 1 leaves the flag unchanged and never sets it.
- R8: alarm_irq is high exactly when alarm_flag is high and control bit 3 is 1.
- R9: When a flag-clearing control write and a matching tick fall in the same cycle, the flag is set afterwards.
- R10: The month alarm field uses BCD months 0x01 to 0x12, so a month register of 0x92 matches a month input of 0x12 and does not match 0x11.
- R11: Writes to any address outside 8 to 14 change no register, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe on each seconds update |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 8 | Current weekday, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD 0x01 to 0x12 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach from the ports is the race between software and hardware: a flag-clearing control write that lands in the same clock as a matching tick. The bench drives the tick and the bus write on the same falling edge, so that the rising edge between them sees both together. It then checks that the flag survives. Partial masks are reached by enabling single fields while the disabled fields hold values that differ from the time inputs. The December month encoding gets a match case and a miss case of its own.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned N_FIELDS   = 6;
  localparam int unsigned FIELD_BASE = 8;
  localparam int unsigned CTRL_ADDR  = 14;
  localparam int unsigned FLAG_BIT   = 0;
  localparam int unsigned IEN_BIT    = 3;
  localparam int unsigned ENB_BIT    = 7;

  typedef logic [DATA_W-1:0] bcd_byte_t;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NF    = N_FIELDS,
  parameter int unsigned BASE  = FIELD_BASE,
  parameter int unsigned CADDR = CTRL_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          flag_q,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] alarm_regs [NF],
  output logic          ien_q,
  output logic          flag_clr
);
  localparam logic [AW-1:0] CTRL_A = AW'(CADDR);

  logic ctrl_wr;
  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_A);
  assign flag_clr = ctrl_wr && !bus_wdata[FLAG_BIT];

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_field
      localparam logic [AW-1:0] MY_A = AW'(BASE + gi);
      logic [DW-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          val_q <= '0;
        else if (bus_wr && (bus_addr == MY_A))
          val_q <= bus_wdata;
      end
      assign alarm_regs[gi] = val_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ien_q <= 1'b0;
    else if (ctrl_wr)
      ien_q <= bus_wdata[IEN_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NF; i++) begin
      if (bus_addr == AW'(BASE + i))
        bus_rdata = alarm_regs[i];
    end
    if (bus_addr == CTRL_A) begin
      bus_rdata[IEN_BIT]  = ien_q;
      bus_rdata[FLAG_BIT] = flag_q;
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ien_q == $past(bus_wdata[IEN_BIT]))); // R2
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NF = N_FIELDS,
  parameter int unsigned EB = ENB_BIT
) (
  input  logic [DW-1:0] alarm_regs [NF],
  input  logic [DW-1:0] cur_time   [NF],
  output logic          any_en,
  output logic          match
);
  logic [NF-1:0] en_vec;
  logic [NF-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_cmp
      logic [DW-1:0] want;
      assign en_vec[gi] = alarm_regs[gi][EB];
      assign want       = {1'b0, alarm_regs[gi][EB-1:0]};
      assign hit_vec[gi] = !en_vec[gi] || (want == cur_time[gi]);
    end
  endgenerate

  assign any_en = |en_vec;
  assign match  = any_en && (&hit_vec);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic match,
  input  logic any_en,
  input  logic flag_clr,
  input  logic ien_q,
  output logic flag_q,
  output logic irq
);
  logic set_now;
  assign set_now = sec_tick && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_now)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  assign irq = flag_q && ien_q;

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && match) |=> flag_q); // R6
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !sec_tick) |=> !flag_q); // R4
  AST_NO_ENABLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !any_en) |=> !flag_q); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(sec_tick && match)) |=> !flag_q); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && sec_tick && match) |=> flag_q); // R9
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_wday,
  input  logic [DW-1:0] cur_day,
  input  logic [DW-1:0] cur_mon,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          alarm_flag,
  output logic          alarm_irq
);
  localparam int unsigned NF = N_FIELDS;

  logic [DW-1:0] alarm_regs [NF];
  logic [DW-1:0] cur_time   [NF];
  logic          ien_q, flag_clr, flag_q, any_en, match;

  assign cur_time[FLD_SEC]  = cur_sec;
  assign cur_time[FLD_MIN]  = cur_min;
  assign cur_time[FLD_HOUR] = cur_hour;
  assign cur_time[FLD_WDAY] = cur_wday;
  assign cur_time[FLD_DAY]  = cur_day;
  assign cur_time[FLD_MON]  = cur_mon;

  alarm_regfile #(.AW(AW), .DW(DW), .NF(NF), .BASE(FIELD_BASE), .CADDR(CTRL_ADDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flag_q     (flag_q),
    .bus_rdata  (bus_rdata),
    .alarm_regs (alarm_regs),
    .ien_q      (ien_q),
    .flag_clr   (flag_clr)
  );

  alarm_field_match #(.DW(DW), .NF(NF), .EB(ENB_BIT)) u_match (
    .alarm_regs (alarm_regs),
    .cur_time   (cur_time),
    .any_en     (any_en),
    .match      (match)
  );

  alarm_flag_ctrl u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .match    (match),
    .any_en   (any_en),
    .flag_clr (flag_clr),
    .ien_q    (ien_q),
    .flag_q   (flag_q),
    .irq      (alarm_irq)
  );

  assign alarm_flag = flag_q;

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_flag) |-> !alarm_irq); // R8
endmodule

// File: tb/cal_alarm_cmp_tb.sv
module cal_alarm_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] cur_wday = 8'h00, cur_day = 8'h00, cur_mon = 8'h01;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       alarm_flag, alarm_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .cur_day(cur_day), .cur_mon(cur_mon),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; cur_day = d; cur_mon = mo;
  endtask

  task automatic clear_all();
    for (int i = 8; i <= 13; i++) wr(4'(i), 8'h00);
    wr(4'd14, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 8; i <= 14; i++) begin
      rd(4'(i), v);
      chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 flag after reset", {7'b0, alarm_flag}, 8'h00);
    chk("R1 irq after reset", {7'b0, alarm_irq}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    for (int i = 8; i <= 13; i++) wr(4'(i), 8'(8'h31 + i));
    for (int i = 8; i <= 13; i++) begin
      rd(4'(i), v);
      chk("R2 readback", v, 8'(8'h31 + i));
    end
    wr(4'd3, 8'hA5);
    wr(4'd15, 8'hFF);
    rd(4'd3, v);  chk("R11 read unmapped 3", v, 8'h00);
    rd(4'd15, v); chk("R11 read unmapped 15", v, 8'h00);
    for (int i = 8; i <= 14; i++) begin
      rd(4'(i), v);
      chk("R11 no side effect", v, (i == 14) ? 8'h00 : 8'(8'h31 + i));
    end
    wr(4'd14, 8'hF6);
    rd(4'd14, v); chk("R2 ctrl bits", v, 8'h00);
    clear_all();
  endtask

  task automatic t_zero_regs();
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    tick();
    chk("R5 zero regs no flag", {7'b0, alarm_flag}, 8'h00);
  endtask

  task automatic t_full_match();
    logic [7:0] v;
    wr(4'd8, 8'hB0); wr(4'd9, 8'hC5); wr(4'd10, 8'h92);
    wr(4'd11, 8'h83); wr(4'd12, 8'h97); wr(4'd13, 8'h86);
    set_time(8'h30, 8'h45, 8'h12, 8'h03, 8'h17, 8'h06);
    repeat (4) @(negedge clk);
    chk("R4 no tick no flag", {7'b0, alarm_flag}, 8'h00);
    tick();
    chk("R6 full match sets flag", {7'b0, alarm_flag}, 8'h01);
    chk("R8 irq masked", {7'b0, alarm_irq}, 8'h00);
    wr(4'd14, 8'h09);
    chk("R7 write 1 keeps flag", {7'b0, alarm_flag}, 8'h01);
    chk("R8 irq enabled", {7'b0, alarm_irq}, 8'h01);
    rd(4'd14, v); chk("R2 ctrl readback", v, 8'h09);
    set_time(8'h31, 8'h45, 8'h12, 8'h03, 8'h17, 8'h06);
    tick();
    chk("R6 sticky on mismatch", {7'b0, alarm_flag}, 8'h01);
    wr(4'd14, 8'h08);
    chk("R7 clear flag", {7'b0, alarm_flag}, 8'h00);
    chk("R8 irq drops", {7'b0, alarm_irq}, 8'h00);
    wr(4'd14, 8'h09);
    chk("R7 write 1 does not set", {7'b0, alarm_flag}, 8'h00);
    clear_all();
  endtask

  task automatic t_masked();
    wr(4'd8, 8'h22);
    wr(4'd9, 8'h95);
    set_time(8'h40, 8'h15, 8'h07, 8'h01, 8'h02, 8'h03);
    tick();
    chk("R3 single field match", {7'b0, alarm_flag}, 8'h01);
    wr(4'd14, 8'h00);
    set_time(8'h40, 8'h16, 8'h07, 8'h01, 8'h02, 8'h03);
    tick();
    chk("R3 enabled field mismatch", {7'b0, alarm_flag}, 8'h00);
    clear_all();
  endtask

  task automatic t_month();
    wr(4'd13, 8'h92);
    wr(4'd12, 8'h31);
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h11);
    tick();
    chk("R10 month 11 misses", {7'b0, alarm_flag}, 8'h00);
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h12);
    tick();
    chk("R10 month 12 hits", {7'b0, alarm_flag}, 8'h01);
    clear_all();
  endtask

  task automatic t_race();
    wr(4'd10, 8'h88);
    wr(4'd14, 8'h08);
    set_time(8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h01);
    @(negedge clk);
    sec_tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd14; bus_wdata = 8'h08;
    @(negedge clk);
    sec_tick = 1'b0; bus_wr = 1'b0;
    chk("R9 set wins over clear", {7'b0, alarm_flag}, 8'h01);
    chk("R8 irq with set wins", {7'b0, alarm_irq}, 8'h01);
    wr(4'd14, 8'h00);
    chk("R7 clear after race", {7'b0, alarm_flag}, 8'h00);
    clear_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_zero_regs();
    t_full_match();
    t_masked();
    t_month();
    t_race();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule